// File: doc/BRIEF.md
# Program Counter and Interrupt Sequencer

This block holds the program counter and the stack pointer of a small 16-bit processor and steps them once for each instruction that retires. Every instruction is two words long. A retiring instruction that is not control flow moves the counter on by two. A control-flow instruction can load an absolute target, add an offset to the counter, push a return address, pop a value off the stack in place of its register operand, raise a software interrupt, and switch the interrupt enable on or off. A hardware interrupt request is accepted only at an instruction boundary, and only while interrupts are enabled. When it is accepted, the instruction at the current address is not executed. The current address is pushed, and execution resumes at address zero.

The block does not own the stack memory. It issues a write request (address and data) for each push and a read request (address) for each pop. The memory answers the read in the same cycle on `stk_rdata`. Any condition test on the instruction is done upstream: `step` together with `is_cf` means that a control-flow instruction passed its condition and is retiring in this cycle.

Top module: `pc_irq_unit`

## Requirements
- R1: While reset is held, and after it is released, the counter is 0, the stack pointer is `SP_INIT` (default 0x0100), interrupts are disabled, and no push or pop is requested.
- R2: A cycle with `step`=0 leaves the counter, the stack pointer and the enable unchanged and requests no push and no pop. A retiring instruction that is not control flow (`is_cf`=0) adds 2 to the counter.
- R3: With `cf_j`=0 the counter is loaded with the selected value. With `cf_j`=1 the selected value is added to the address of the control-flow instruction, wrapping modulo 2^16. The selected value is the operand register value, or the popped value when a pop occurs.
- R4: With `cf_s`=1, the address of the control-flow instruction plus 2 is pushed. The stack grows downward: the write goes to the stack pointer minus one, and the stack pointer decrements by one.
- R5: With `cf_p`=1 and no software interrupt, a read is requested at the stack pointer, `stk_rdata` replaces the operand, and the stack pointer increments. When push and pop happen in the same instruction, the pop is done first: the write goes to the address just read, and the stack pointer ends unchanged.
- R6: With `cf_i`=1 while interrupts are enabled, the counter goes to 0 whatever `cf_j` holds, no pop is requested, and a push still occurs if `cf_s`=1.
- R7: With `cf_i`=1 while interrupts are disabled, `cf_j` and `cf_p` act exactly as they do with `cf_i`=0.
- R8: The 2-bit toggle field `cf_tt` sets the enable: 2'b10 clears it, 2'b11 sets it, and 2'b00 and 2'b01 leave it unchanged. The change is applied after the software-interrupt test, so a set in the same instruction does not trigger that interrupt and a clear in the same instruction does not block it.
- R9: When `step`=1, `hw_irq`=1 and interrupts are enabled, the current counter value is pushed, the counter goes to 0, the control-flow inputs are ignored, and the enable keeps its value. While interrupts are disabled, `hw_irq` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | An instruction retires in this cycle |
| is_cf | input | 1 | The retiring instruction is control flow and passed its condition |
| cf_j | input | 1 | 0 = absolute target, 1 = add to counter |
| cf_s | input | 1 | Push the return address |
| cf_p | input | 1 | Pop and use the stack value as operand |
| cf_i | input | 1 | Software interrupt request |
| cf_tt | input | 2 | Enable toggle: 10 off, 11 on, 0x unchanged |
| opnd | input | W | Operand register value |
| stk_rdata | input | W | Stack read data for `pop_addr`, same cycle |
| hw_irq | input | 1 | Hardware interrupt request |
| pc | output | W | Program counter |
| sp | output | W | Stack pointer |
| irq_en | output | 1 | Interrupt enable |
| push_en | output | 1 | Stack write request |
| push_addr | output | W | Stack write address |
| push_data | output | W | Stack write data |
| pop_en | output | 1 | Stack read request |
| pop_addr | output | W | Stack read address |

## Verification
The control-flow path is driven with absolute loads, forward and backward relative offsets, calls, returns, returns taken as relative offsets, and a combined push and pop. Together these show whether the target comes from the operand or the stack, how the adder wraps, and in which order the two stack pointer updates happen. Software interrupts are tried with interrupts off and on, and combined with an enable toggle in the same instruction, so that the order of the interrupt test and the toggle can be told apart. Hardware requests arrive while interrupts are disabled, while enabled, and with `step` low, and each time carry control-flow fields that must be ignored. This separates acceptance at an instruction boundary from the execution of the instruction itself.

// File: rtl/pc_irq_unit.sv
module pc_irq_unit #(
  parameter int W = 16,
  parameter int INSTR_WORDS = 2,
  parameter logic [W-1:0] SP_INIT = 16'h0100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         is_cf,
  input  logic         cf_j,
  input  logic         cf_s,
  input  logic         cf_p,
  input  logic         cf_i,
  input  logic [1:0]   cf_tt,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] stk_rdata,
  input  logic         hw_irq,
  output logic [W-1:0] pc,
  output logic [W-1:0] sp,
  output logic         irq_en,
  output logic         push_en,
  output logic [W-1:0] push_addr,
  output logic [W-1:0] push_data,
  output logic         pop_en,
  output logic [W-1:0] pop_addr
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] INCR = W'(INSTR_WORDS);

  logic [W-1:0] pc_q, sp_q, sp_mid, val, tgt;
  logic         en_q, take_hw, do_cf, swi;

  assign take_hw = step && hw_irq && en_q;
  assign do_cf   = step && is_cf && !take_hw;
  assign swi     = do_cf && cf_i && en_q;

  assign pop_en   = do_cf && cf_p && !swi;
  assign pop_addr = sp_q;
  assign sp_mid   = pop_en ? sp_q + ONE : sp_q;

  assign push_en   = take_hw || (do_cf && cf_s);
  assign push_addr = sp_mid - ONE;
  assign push_data = take_hw ? pc_q : pc_q + INCR;

  assign val = pop_en ? stk_rdata : opnd;
  assign tgt = swi ? '0 : (cf_j ? pc_q + val : val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= SP_INIT;
      en_q <= 1'b0;
    end else if (step) begin
      sp_q <= push_en ? sp_mid - ONE : sp_mid;
      if (take_hw)
        pc_q <= '0;
      else if (do_cf) begin
        pc_q <= tgt;
        if (cf_tt[1]) en_q <= cf_tt[0];
      end else
        pc_q <= pc_q + INCR;
    end
  end

  assign pc     = pc_q;
  assign sp     = sp_q;
  assign irq_en = en_q;
endmodule

// File: rtl/pc_irq_unit_chk.sv
module pc_irq_unit_chk #(
  parameter int W = 16,
  parameter int INSTR_WORDS = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step,
  input logic         is_cf,
  input logic         cf_i,
  input logic         hw_irq,
  input logic [W-1:0] pc,
  input logic [W-1:0] sp,
  input logic         irq_en,
  input logic         push_en,
  input logic [W-1:0] push_addr,
  input logic [W-1:0] push_data,
  input logic         pop_en,
  input logic [W-1:0] pop_addr
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> (!push_en && !pop_en));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(pc) && $stable(sp) && $stable(irq_en)));

  p_seq_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !is_cf && !(hw_irq && irq_en)) |=> pc == $past(pc) + W'(INSTR_WORDS));

  p_push_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && push_en && !pop_en) |=> sp == $past(sp) - W'(1));

  p_pop_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pop_en && !push_en) |=> sp == $past(sp) + W'(1));

  p_swap_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && pop_en) |-> push_addr == pop_addr);

  p_swi_nopop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_cf && cf_i && irq_en) |-> !pop_en);

  p_swi_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_cf && cf_i && irq_en) |=> pc == '0);

  p_en_only_cf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && is_cf && !(hw_irq && irq_en)) |=> $stable(irq_en));

  p_hw_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hw_irq && irq_en) |-> (push_en && push_data == pc && !pop_en));

  p_hw_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hw_irq && irq_en) |=> (pc == '0 && irq_en));
endmodule

bind pc_irq_unit pc_irq_unit_chk #(.W(W), .INSTR_WORDS(INSTR_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .is_cf(is_cf), .cf_i(cf_i),
  .hw_irq(hw_irq), .pc(pc), .sp(sp), .irq_en(irq_en), .push_en(push_en),
  .push_addr(push_addr), .push_data(push_data), .pop_en(pop_en),
  .pop_addr(pop_addr)
);

// File: tb/pc_irq_unit_test.sv
module pc_irq_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic step = 0, is_cf = 0, cf_j = 0, cf_s = 0, cf_p = 0, cf_i = 0, hw_irq = 0;
  logic [1:0] cf_tt = 0;
  logic [15:0] opnd = 0, stk_rdata;
  logic [15:0] pc, sp, push_addr, push_data, pop_addr;
  logic irq_en, push_en, pop_en;

  logic [15:0] stk [0:255];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_pc = 0, m_sp = 16'h0100;
  bit m_en = 0;
  logic [15:0] m_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign stk_rdata = stk[pop_addr[7:0]];
  always @(posedge clk) if (push_en) stk[push_addr[7:0]] <= push_data;

  pc_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .step(step), .is_cf(is_cf), .cf_j(cf_j),
    .cf_s(cf_s), .cf_p(cf_p), .cf_i(cf_i), .cf_tt(cf_tt), .opnd(opnd),
    .stk_rdata(stk_rdata), .hw_irq(hw_irq), .pc(pc), .sp(sp),
    .irq_en(irq_en), .push_en(push_en), .push_addr(push_addr),
    .push_data(push_data), .pop_en(pop_en), .pop_addr(pop_addr)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit st, bit cf, bit j, bit s, bit p, bit i, bit [1:0] tt,
                     logic [15:0] op, bit irq, string req);
    bit e_push = 0, e_pop = 0, swi;
    logic [15:0] e_pa = 0, e_pd = 0, e_popa = 0, v, n_pc, n_sp;
    bit n_en;
    step = st; is_cf = cf; cf_j = j; cf_s = s; cf_p = p; cf_i = i;
    cf_tt = tt; opnd = op; hw_irq = irq;
    #1;
    n_pc = m_pc; n_sp = m_sp; n_en = m_en;
    if (st) begin
      if (irq && m_en) begin
        e_push = 1; n_sp = m_sp - 1; e_pa = n_sp; e_pd = m_pc;
        m_q.push_front(m_pc); n_pc = 0;
      end else if (cf) begin
        swi = i && m_en;
        v = op;
        if (p && !swi) begin
          e_pop = 1; e_popa = m_sp; v = m_q.pop_front(); n_sp = n_sp + 1;
        end
        n_pc = swi ? 16'h0 : (j ? m_pc + v : v);
        if (s) begin
          e_push = 1; n_sp = n_sp - 1; e_pa = n_sp; e_pd = m_pc + 2;
          m_q.push_front(m_pc + 16'd2);
        end
        if (tt == 2'b10) n_en = 0;
        if (tt == 2'b11) n_en = 1;
      end else n_pc = m_pc + 2;
    end
    chk(req, "push_en", push_en, e_push);
    chk(req, "pop_en", pop_en, e_pop);
    if (e_push) begin
      chk(req, "push_addr", push_addr, e_pa);
      chk(req, "push_data", push_data, e_pd);
    end
    if (e_pop) chk(req, "pop_addr", pop_addr, e_popa);
    @(posedge clk); @(negedge clk);
    m_pc = n_pc; m_sp = n_sp; m_en = n_en;
    chk(req, "pc", pc, m_pc);
    chk(req, "sp", sp, m_sp);
    chk(req, "irq_en", irq_en, m_en);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) stk[k] = 16'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pc", pc, 16'h0);
    chk("R1", "sp", sp, 16'h0100);
    chk("R1", "irq_en", irq_en, 0);
    chk("R1", "push_en", push_en, 0);
    chk("R1", "pop_en", pop_en, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "pc after release", pc, 16'h0);
    // R2 idle cycles with noisy fields, then sequential advance
    cyc(0, 1, 1, 1, 1, 0, 2'b11, 16'h1234, 1, "R2");
    cyc(0, 1, 0, 1, 0, 1, 2'b10, 16'h0055, 0, "R2");
    cyc(1, 0, 1, 1, 1, 1, 2'b11, 16'h7777, 0, "R2");
    cyc(1, 0, 0, 0, 0, 0, 2'b00, 16'h0000, 0, "R2");
    // R3 absolute and relative
    cyc(1, 1, 0, 0, 0, 0, 2'b00, 16'h0040, 0, "R3");
    cyc(1, 1, 1, 0, 0, 0, 2'b00, 16'h0010, 0, "R3");
    cyc(1, 1, 1, 0, 0, 0, 2'b00, 16'hFFF0, 0, "R3");
    cyc(1, 1, 1, 0, 0, 0, 2'b01, 16'hFF00, 0, "R3");
    // R4 call, R5 return
    cyc(1, 1, 0, 1, 0, 0, 2'b00, 16'h0200, 0, "R4");
    cyc(1, 0, 0, 0, 0, 0, 2'b00, 16'h0000, 0, "R2");
    cyc(1, 1, 0, 1, 0, 0, 2'b00, 16'h0300, 0, "R4");
    cyc(1, 1, 0, 0, 1, 0, 2'b00, 16'hDEAD, 0, "R5");
    cyc(1, 1, 0, 1, 0, 0, 2'b00, 16'h0400, 0, "R4");
    cyc(1, 1, 0, 1, 1, 0, 2'b00, 16'hBEEF, 0, "R5");
    cyc(1, 1, 1, 0, 1, 0, 2'b00, 16'hBEEF, 0, "R5");
    cyc(1, 1, 0, 0, 1, 0, 2'b00, 16'hBEEF, 0, "R5");
    // R7 software interrupt while disabled acts normally
    cyc(1, 1, 0, 1, 0, 1, 2'b00, 16'h0500, 0, "R7");
    cyc(1, 1, 0, 0, 1, 1, 2'b01, 16'h0000, 0, "R7");
    // R8 enable in same instruction does not trigger
    cyc(1, 1, 1, 0, 0, 1, 2'b11, 16'h0008, 0, "R8");
    cyc(1, 1, 0, 0, 0, 0, 2'b01, 16'h0600, 0, "R8");
    // R6 software interrupt with push and pop request
    cyc(1, 1, 1, 1, 1, 1, 2'b00, 16'h0100, 0, "R6");
    cyc(1, 1, 0, 0, 0, 1, 2'b00, 16'h0700, 0, "R6");
    // R8 disable in same instruction still interrupts
    cyc(1, 1, 0, 0, 0, 0, 2'b00, 16'h0800, 0, "R8");
    cyc(1, 1, 0, 0, 0, 1, 2'b10, 16'h0900, 0, "R8");
    // R9 ignored while disabled
    cyc(1, 0, 0, 0, 0, 0, 2'b00, 16'h0000, 1, "R9");
    cyc(1, 1, 0, 1, 1, 0, 2'b11, 16'h0A00, 1, "R9");
    // R9 taken while enabled, fields ignored
    cyc(1, 1, 0, 1, 1, 1, 2'b10, 16'h0B00, 1, "R9");
    cyc(1, 0, 0, 0, 0, 0, 2'b00, 16'h0000, 1, "R9");
    cyc(0, 0, 0, 0, 0, 0, 2'b00, 16'h0000, 1, "R9");
    cyc(1, 1, 0, 0, 1, 0, 2'b00, 16'h0000, 0, "R5");
    cyc(1, 1, 0, 0, 1, 0, 2'b10, 16'h0000, 0, "R8");
    cyc(1, 1, 0, 0, 0, 0, 2'b00, 16'hFFFE, 0, "R3");
    cyc(1, 0, 0, 0, 0, 0, 2'b00, 16'h0000, 0, "R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule